// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller connects a simple synchronous request port to an asynchronous DRAM of 64K one-bit words. The DRAM exposes only eight address pins, so each access is split into two phases on the same bus. The row phase presents the upper address byte under a falling row strobe. The column phase presents the lower address byte under a falling column strobe. A client raises a request with a read/write flag, a 16-bit word address and one bit of write data. The client waits for `req_ready`, and for a read it collects the bit when `rd_valid` pulses.

Once a row has been opened it stays open. A following request to the same row costs only a column strobe. A request to a different row first closes the open row with a precharge and then runs a full row-then-column cycle. A free-running refresh timer raises a refresh request at a fixed interval. The request is served between accesses by closing any open row and strobing the next refresh row with the row strobe alone. Every analog timing rule is a parameter counted in clock cycles.

The sequencer has seven states:
- PG_PRECHARGE: both strobes high for T_RP cycles. This is also the reset state.
- PG_IDLE: precharged, no row open.
- PG_ROW_OPEN: row strobe low with the row address, for T_RCD cycles.
- PG_COL_STROBE: column strobe low with the column address, for T_CAS cycles.
- PG_COL_RECOVER: column strobe high again, for T_CP cycles.
- PG_PAGE_READY: the row is open and the controller waits.
- PG_REFRESH: row strobe only, for T_REF_RAS cycles.

The transitions are:
- PG_PRECHARGE goes to PG_ROW_OPEN when an access is pending. Otherwise it goes to PG_REFRESH when a refresh is due, and otherwise to PG_IDLE.
- PG_IDLE goes to PG_REFRESH when a refresh is due, or to PG_ROW_OPEN when a request is accepted.
- PG_ROW_OPEN goes to PG_COL_STROBE.
- PG_COL_STROBE goes to PG_COL_RECOVER.
- PG_COL_RECOVER goes to PG_PAGE_READY.
- PG_PAGE_READY goes to PG_PRECHARGE on a refresh or a row miss, and to PG_COL_STROBE on a row hit.
- PG_REFRESH goes to PG_PRECHARGE.

Top module: `pgdram_ctrl`

## Requirements
- R1: During and after reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high. `req_ready` stays low for the first T_RP cycles after reset release and is high from cycle T_RP on.
- R2: At each row-strobe fall of an access, `dram_addr` carries `req_addr[15:8]`. At each column-strobe fall it carries `req_addr[7:0]`.
- R3: A write (`req_write`=1) drives `dram_we_n` low for the whole column strobe, with `dram_din` equal to `req_wdata`. This stores that bit at the addressed word.
- R4: A read (`req_write`=0) keeps `dram_we_n` high. It samples `dram_dout` at the end of the column strobe and presents it on `rd_data`, with a one-cycle `rd_valid` pulse.
- R5: A request to the currently open row issues one column strobe and no new row strobe. `rd_valid` comes T_CAS+T_CP+1 clock edges after the accepting edge, counting that edge.
- R6: A request to a row other than the open one raises the row strobe for T_RP cycles, then reopens the row. `rd_valid` comes T_RP+T_RCD+T_CAS+T_CP+1 edges after acceptance, and the row strobe stays low for at least T_RCD cycles before the column strobe falls.
- R7: A request accepted with no row open skips the precharge. `rd_valid` comes T_RCD+T_CAS+T_CP+1 edges after acceptance.
- R8: The row strobe is high for at least T_RP consecutive cycles before every fall.
- R9: `req_ready` is low from the cycle after an accepted request until the access completes. A request raised while `req_ready` is low is ignored: it produces no column strobe and writes nothing.
- R10: A refresh becomes due every REF_INTERVAL cycles. It is served only between accesses. It holds the row strobe low for exactly T_REF_RAS cycles with the column strobe high, so with the controller idle, successive refresh row strobes fall exactly REF_INTERVAL cycles apart.
- R11: Refresh row addresses start at 0 after reset, increase by one per refresh and wrap from 255 to 0.
- R12: The column strobe is low only while the row strobe is low. Write enable is low only while the column strobe is low. `dram_addr` does not change while the column strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, upper byte row, lower byte column |
| req_wdata | input | 1 | Write data bit |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_din | output | 1 | Data to the DRAM |
| dram_dout | input | 1 | Data from the DRAM |

## Verification
On every cycle, the assertions check the pin-level rules that hold whatever the traffic:
- the strobe nesting and address hold of R12;
- the precharge minimum of R8;
- the drop of ready after acceptance in R9;
- that read data only appears with the row open and the column strobe ended.

Other behaviour can only be shown by the bench's scenarios, which run against a behavioural DRAM model:
- the latencies of the hit, miss and closed-row paths;
- the address split and stored data;
- the ignoring of a request raised while busy;
- the exact refresh spacing and the row sequence with its wrap.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        PG_PRECHARGE   = 3'd0,
        PG_IDLE        = 3'd1,
        PG_ROW_OPEN    = 3'd2,
        PG_COL_STROBE  = 3'd3,
        PG_COL_RECOVER = 3'd4,
        PG_PAGE_READY  = 3'd5,
        PG_REFRESH     = 3'd6
    } pg_state_e;

    typedef enum logic [1:0] {
        AMUX_ROW = 2'd0,
        AMUX_COL = 2'd1,
        AMUX_REF = 2'd2
    } amux_sel_e;

    function automatic int pg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgdram_delay_counter.sv
module pgdram_delay_counter #(
    parameter int CNT_W     = 4,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Loaded with (duration - 1) on state entry; done when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pgdram_refresh_timer.sv
module pgdram_refresh_timer #(
    parameter int INTERVAL = 31250,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);

    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick_cnt;
    logic          wrap;

    assign wrap = (tick_cnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
            ref_row  <= '0;
        end else begin
            tick_cnt <= wrap ? '0 : tick_cnt + 1'b1;
            // a new tick wins over an acknowledge in the same cycle (R10)
            if (wrap) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
            // row sequence for R11
            if (ack) begin
                ref_row <= ref_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgdram_addr_mux.sv
module pgdram_addr_mux
    import pgdram_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  amux_sel_e        sel,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] pin_addr
);

    always_comb begin
        unique case (sel)
            AMUX_COL: pin_addr = col;
            AMUX_REF: pin_addr = ref_row;
            default:  pin_addr = row;
        endcase
    end

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 1,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 31250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_wdata,
    output logic                req_ready,
    output logic                rd_valid,
    output logic                rd_data,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_din,
    input  logic                dram_dout
);

    localparam int ROW_W = ADDR_W / 2;
    localparam int T_MAX = pg_max(pg_max(T_RP, T_RCD), pg_max(pg_max(T_CAS, T_CP), T_REF_RAS));
    localparam int CNT_W = $clog2(T_MAX + 1);

    pg_state_e        state, state_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             ref_pending, ref_ack;
    logic [ROW_W-1:0] ref_row;

    logic              job_busy, job_write, job_wdata;
    logic [ADDR_W-1:0] job_addr;
    logic              accept, row_hit;
    logic              nxt_write, nxt_wdata;
    logic [ADDR_W-1:0] nxt_addr;
    amux_sel_e         amux_sel;
    logic [ROW_W-1:0]  amux_out;

    pgdram_delay_counter #(
        .CNT_W    (CNT_W),
        .RESET_VAL(T_RP - 1)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    pgdram_refresh_timer #(
        .INTERVAL(REF_INTERVAL),
        .ROW_W   (ROW_W)
    ) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ref_ack),
        .pending(ref_pending),
        .ref_row(ref_row)
    );

    // Handshake: accept only while waiting and no refresh is due (R9).
    assign req_ready = ((state == PG_IDLE) || (state == PG_PAGE_READY)) && !ref_pending;
    assign accept    = req_valid && req_ready;
    assign row_hit   = (req_addr[ADDR_W-1:ROW_W] == job_addr[ADDR_W-1:ROW_W]);

    // The job that the next cycle works on.
    assign nxt_write = accept ? req_write : job_write;
    assign nxt_wdata = accept ? req_wdata : job_wdata;
    assign nxt_addr  = accept ? req_addr  : job_addr;

    // Next-state logic.
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_ack  = 1'b0;
        unique case (state)
            PG_PRECHARGE: begin
                if (tmr_done) begin
                    if (job_busy) begin
                        state_d  = PG_ROW_OPEN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_RCD - 1);
                    end else if (ref_pending) begin
                        state_d  = PG_REFRESH;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_REF_RAS - 1);
                    end else begin
                        state_d = PG_IDLE;
                    end
                end
            end
            PG_IDLE: begin
                if (ref_pending) begin
                    state_d  = PG_REFRESH;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_REF_RAS - 1);
                end else if (accept) begin
                    state_d  = PG_ROW_OPEN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RCD - 1);
                end
            end
            PG_ROW_OPEN: begin
                if (tmr_done) begin
                    state_d  = PG_COL_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CAS - 1);
                end
            end
            PG_COL_STROBE: begin
                if (tmr_done) begin
                    state_d  = PG_COL_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CP - 1);
                end
            end
            PG_COL_RECOVER: begin
                if (tmr_done) begin
                    state_d = PG_PAGE_READY;
                end
            end
            PG_PAGE_READY: begin
                if (ref_pending || (accept && !row_hit)) begin
                    state_d  = PG_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RP - 1);
                end else if (accept) begin
                    state_d  = PG_COL_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CAS - 1);
                end
            end
            PG_REFRESH: begin
                if (tmr_done) begin
                    state_d  = PG_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RP - 1);
                    ref_ack  = 1'b1;
                end
            end
            default: begin
                state_d  = PG_PRECHARGE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 1);
            end
        endcase
    end

    // State register; reset enters the precharge state (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PG_PRECHARGE;
        end else begin
            state <= state_d;
        end
    end

    // Latched job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_busy  <= 1'b0;
            job_write <= 1'b0;
            job_wdata <= 1'b0;
            job_addr  <= '0;
        end else begin
            if (accept) begin
                job_busy  <= 1'b1;
                job_write <= req_write;
                job_wdata <= req_wdata;
                job_addr  <= req_addr;
            end else if ((state == PG_COL_STROBE) && tmr_done) begin
                job_busy <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (state_d)
            PG_REFRESH:    amux_sel = AMUX_REF;
            PG_COL_STROBE: amux_sel = AMUX_COL;
            default:       amux_sel = AMUX_ROW;
        endcase
    end

    pgdram_addr_mux #(
        .ROW_W(ROW_W)
    ) u_amux (
        .sel     (amux_sel),
        .row     (nxt_addr[ADDR_W-1:ROW_W]),
        .col     (nxt_addr[ROW_W-1:0]),
        .ref_row (ref_row),
        .pin_addr(amux_out)
    );

    // Output register: the pins follow the state they belong to (R2, R3, R4, R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_addr  <= '0;
            dram_din   <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= 1'b0;
        end else begin
            dram_ras_n <= !(state_d inside {PG_ROW_OPEN, PG_COL_STROBE, PG_COL_RECOVER,
                                            PG_PAGE_READY, PG_REFRESH});
            dram_cas_n <= !(state_d == PG_COL_STROBE);
            dram_we_n  <= !((state_d == PG_COL_STROBE) && nxt_write);
            dram_addr  <= amux_out;
            dram_din   <= nxt_wdata;
            rd_valid   <= (state == PG_COL_RECOVER) && tmr_done && !job_write;
            if ((state == PG_COL_STROBE) && tmr_done && !job_write) begin
                rd_data <= dram_dout;
            end
        end
    end

endmodule

// File: rtl/pgdram_ctrl_checker.sv
module pgdram_ctrl_checker #(
    parameter int ROW_W = 8,
    parameter int T_RP  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic [ROW_W-1:0] dram_addr
);

    localparam int HW = $clog2(T_RP + 2) + 1;

    logic [HW-1:0] hi_cnt;

    // Consecutive cycles with the row strobe high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (dram_ras_n) begin
            if (hi_cnt != {HW{1'b1}}) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_cas_in_ras_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    assert_we_in_cas_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_cas_n);

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

    assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_RP)));

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_read_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!dram_ras_n && dram_cas_n));

endmodule

bind pgdram_ctrl pgdram_ctrl_checker #(
    .ROW_W(ROW_W),
    .T_RP (T_RP)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_addr (dram_addr)
);

// File: tb/tb_pgdram_ctrl.sv
module tb_pgdram_ctrl;

    localparam int T_RP  = 2;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_CP  = 1;
    localparam int T_REF = 3;
    localparam int REFI  = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, rd_valid, rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
    logic [7:0]  dram_addr;
    logic        dram_dout = 1'b0;

    int checks = 0, fails = 0;
    bit finished = 0;
    int cyc = 0;

    pgdram_ctrl #(
        .ADDR_W(16), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_REF_RAS(T_REF), .REF_INTERVAL(REFI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural DRAM model and pin monitor, evaluated between edges.
    bit mdl_mem [int];
    bit exp_mem [int];
    logic [7:0] row_l = '0, cas_row = '0, cas_col = '0, prev_addr = '0;
    bit prev_ras = 1, prev_cas = 1, cas_we = 0, ref_wrapped = 0, have_ref = 0;
    int low_cnt = 0, hi_cnt = 0, cas_in_win = 0, opens = 0, cas_falls = 0;
    int ref_events = 0, exp_ref = 0, ras_fall_cyc = 0, prev_ref_fall = 0, ref_intv = 0;
    int prech_bad = 0, rcd_bad = 0, strobe_bad = 0, ref_len_bad = 0, ref_seq_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1; prev_cas = 1; hi_cnt = 0;
        end else begin
            if (!dram_cas_n && dram_ras_n) strobe_bad++;
            if (!dram_we_n && dram_cas_n) strobe_bad++;
            if (!dram_cas_n && !prev_cas && dram_addr != prev_addr) strobe_bad++;
            if (!dram_ras_n) begin
                if (prev_ras) begin
                    if (hi_cnt < T_RP) prech_bad++;
                    row_l = dram_addr; low_cnt = 1; cas_in_win = 0; ras_fall_cyc = cyc;
                end else begin
                    low_cnt++;
                end
                hi_cnt = 0;
            end else begin
                if (!prev_ras && cas_in_win == 0) begin
                    if (low_cnt != T_REF) ref_len_bad++;
                    if (int'(row_l) != exp_ref) ref_seq_bad++;
                    if (row_l == 8'd255) ref_wrapped = 1;
                    exp_ref = (exp_ref + 1) % 256;
                    if (have_ref) ref_intv = ras_fall_cyc - prev_ref_fall;
                    prev_ref_fall = ras_fall_cyc; have_ref = 1;
                    ref_events++;
                end
                hi_cnt++;
            end
            if (!dram_cas_n && prev_cas) begin
                if (cas_in_win == 0) begin
                    opens++;
                    if (low_cnt - 1 < T_RCD) rcd_bad++;
                end
                cas_in_win++; cas_falls++;
                cas_row = row_l; cas_col = dram_addr; cas_we = !dram_we_n;
                if (!dram_we_n) mdl_mem[{row_l, dram_addr}] = dram_din;
                else dram_dout = mdl_mem.exists({row_l, dram_addr}) ? mdl_mem[{row_l, dram_addr}] : 1'b0;
            end
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_addr = dram_addr;
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    function automatic bit exp_rd(input logic [15:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 1'b0;
    endfunction

    function automatic bit mdl_rd(input logic [15:0] a);
        return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : 1'b0;
    endfunction

    task automatic wait_ready();
        for (int g = 0; g < 5000 && !req_ready; g++) @(negedge clk);
    endtask

    // One access; path 0 = closed row, 1 = row hit, 2 = row miss.
    task automatic do_access(input bit wr, input logic [15:0] a, input bit d, output int path);
        int lat, exp_lat, opens0, cas0;
        bit got;
        wait_ready();
        path = dram_ras_n ? 0 : ((row_l == a[15:8]) ? 1 : 2);
        exp_lat = T_CAS + T_CP + 1 + ((path != 1) ? T_RCD : 0) + ((path == 2) ? T_RP : 0);
        opens0 = opens; cas0 = cas_falls;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; lat = 1;
        check(!req_ready, "R9 ready low after accept", int'(req_ready), 0);
        if (!wr) begin
            while (!rd_valid && lat < 60) begin @(negedge clk); lat++; end
            got = rd_data;
            check(rd_valid, "R4 read data valid pulse", int'(rd_valid), 1);
            if (path == 1) check(lat == exp_lat, "R5 hit latency", lat, exp_lat);
            else if (path == 0) check(lat == exp_lat, "R7 closed-row latency", lat, exp_lat);
            else check(lat == exp_lat, "R6 miss latency", lat, exp_lat);
            check(got == exp_rd(a), "R4 read data", int'(got), int'(exp_rd(a)));
            check(!cas_we, "R4 write enable high on read", int'(cas_we), 0);
        end
        wait_ready();
        check(opens - opens0 == ((path == 1) ? 0 : 1), "R5 row strobes per access", opens - opens0, (path == 1) ? 0 : 1);
        check(cas_falls - cas0 == 1, "R5 one column strobe", cas_falls - cas0, 1);
        check(cas_row == a[15:8], "R2 row half", int'(cas_row), int'(a[15:8]));
        check(cas_col == a[7:0], "R2 column half", int'(cas_col), int'(a[7:0]));
        if (wr) begin
            exp_mem[int'(a)] = d;
            check(cas_we, "R3 write enable low", int'(cas_we), 1);
            check(mdl_rd(a) == d, "R3 stored bit", int'(mdl_rd(a)), int'(d));
        end
    endtask

    task automatic t_reset();
        int n;
        repeat (5) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        rst_n = 1;
        @(negedge clk);
        n = 1;
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high after reset", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        check(!req_ready, "R1 ready low during precharge", int'(req_ready), 0);
        while (!req_ready && n < 20) begin @(negedge clk); n++; end
        check(n == T_RP, "R1 ready after initial precharge", n, T_RP);
    endtask

    task automatic t_closed();
        int p;
        do_access(1, 16'h1234, 1, p);
        check(p == 0, "R7 first access on closed row", p, 0);
        do_access(0, 16'h1234, 0, p);
        check(p == 1, "R5 second access hits", p, 1);
    endtask

    task automatic t_burst();
        int p, hits = 0;
        for (int i = 0; i < 8; i++) do_access(1, {8'h12, 8'(i * 8 + 3)}, 1'(i ^ (i >> 1)), p);
        for (int i = 0; i < 8; i++) begin
            do_access(0, {8'h12, 8'(i * 8 + 3)}, 0, p);
            if (p == 1) hits++;
        end
        check(hits >= 6, "R5 page hits in burst", hits, 6);
    endtask

    task automatic t_miss();
        int p, misses = 0;
        do_access(1, 16'hAB40, 1, p);
        for (int i = 0; i < 8; i++) begin
            do_access(0, (i % 2 == 0) ? 16'h1203 : 16'hAB40, 0, p);
            if (p == 2) misses++;
        end
        check(misses >= 6, "R6 row misses when alternating", misses, 6);
    endtask

    task automatic t_busy();
        int cas0, p;
        wait_ready();
        cas0 = cas_falls;
        req_valid = 1; req_write = 0; req_addr = 16'h5511; req_wdata = 0;
        @(negedge clk);
        req_write = 1; req_addr = 16'h5522; req_wdata = 1;
        @(negedge clk);
        req_valid = 0;
        wait_ready();
        check(cas_falls - cas0 == 1, "R9 busy request gave no strobe", cas_falls - cas0, 1);
        check(mdl_rd(16'h5522) == 0, "R9 busy write ignored", int'(mdl_rd(16'h5522)), 0);
        do_access(0, 16'h5522, 0, p);
    endtask

    task automatic t_refresh();
        int e0, p;
        e0 = ref_events;
        for (int g = 0; g < 5 * REFI && ref_events < e0 + 3; g++) @(negedge clk);
        check(ref_events >= e0 + 3, "R10 refreshes occur while idle", ref_events - e0, 3);
        check(ref_intv == REFI, "R10 refresh spacing", ref_intv, REFI);
        check(ref_len_bad == 0, "R10 refresh strobe length", ref_len_bad, 0);
        do_access(0, 16'h1203, 0, p);
        check(p == 0, "R10 refresh closed the row", p, 0);
        for (int g = 0; g < 300 * REFI && ref_events < 260; g++) @(negedge clk);
        check(ref_wrapped && ref_events >= 258, "R11 refresh row wraps", ref_events, 258);
        check(ref_seq_bad == 0, "R11 refresh row sequence", ref_seq_bad, 0);
        do_access(0, {8'h12, 8'(5 * 8 + 3)}, 0, p);
    endtask

    initial begin
        t_reset();
        t_closed();
        t_burst();
        t_miss();
        t_busy();
        t_refresh();
        check(prech_bad == 0, "R8 precharge before row strobe", prech_bad, 0);
        check(rcd_bad == 0, "R6 row-to-column delay", rcd_bad, 0);
        check(strobe_bad == 0, "R12 strobe nesting and address hold", strobe_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule